// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the software-visible state of a memory-management unit: the control word, the context table pointer, the current context number, the TLB replacement control word, and the synchronous fault status and fault address. Software reaches it through an alternate-space port. That port carries a write strobe, a read strobe, a 5-bit register index and a 32-bit data word. Each writable register applies its own write mask. The masks are parameters, so one design can cover several processor variants that implement different numbers of pointer, context or status bits.

Some changes alter the translation state. When a write changes the translation enable, no-fault or boot-mode bit of the control word, or changes the stored context number, the bank raises a one-cycle flush pulse for the TLB. The bank also adds the shifted context table pointer to the shifted context number to form the physical address of the current context table entry, which a table walker can use. Fault information enters through a capture strobe. A read through the read-and-clear view of the fault status clears that register.

Top module: `mmu_regbank`

## Requirements
- R1: After reset, the control word reads as IMPL_VER in bits 31:24 and zero in bits 23:0. Every other register reads zero, and the flush output is 0.
- R2: A write to index 0x00 replaces control bits 23:0 with the write data. Bits 31:24 always read IMPL_VER.
- R3: A write to index 0x00 makes the flush output 1 for the cycle after the write edge if it changes control bit 0 (enable), bit 1 (no-fault) or bit BM_BIT (boot mode, default 14). A control write that changes only other bits leaves flush at 0, and flush never stays high longer than the cycle after the write.
- R4: A write to index 0x01 stores the data ANDed with CTP_MASK (default 0x007FFFF0). The stored value reads back at index 0x01.
- R5: A write to index 0x02 stores the data ANDed with CTX_MASK (default 0x3F). Flush is 1 in the following cycle only if the stored value differs from the previous one.
- R6: Writes to index 0x03 and index 0x04 change no register and cause no flush.
- R7: A write to index 0x10 stores the data ANDed with TRC_MASK (default 0x00FFFFFF). The stored value reads back at index 0x10.
- R8: A write to index 0x13 loads the fault status with the data ANDed with FSR_MASK (default 0x00016FFF). A write to index 0x14 loads the fault address unmasked. The fault status reads at indices 0x03 and 0x13, and the fault address reads at indices 0x04 and 0x14.
- R9: walk_addr equals (context table pointer << 4) + (context number << 2), computed at PAW bits.
- R10: Writes to any index other than 0x00, 0x01, 0x02, 0x03, 0x04, 0x10, 0x13 and 0x14 change no register and cause no flush.
- R11: While rd_en is high with index 0x03, rdata shows the fault status, and the fault status is zero after that edge. A read at index 0x13 does not clear it, and rdata with rd_en low has no side effect.
- R12: A capture (fault_cap high) loads the fault status with fault_status_in ANDed with FSR_MASK and loads the fault address with fault_addr_in. A capture takes priority over a same-cycle read-clear and over a same-cycle write to index 0x13 or 0x14.
- R13: rdata is zero for any unlisted index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| idx | input | 5 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the indexed register (combinational) |
| fault_cap | input | 1 | Fault capture strobe |
| fault_status_in | input | 32 | Fault status to capture |
| fault_addr_in | input | 32 | Fault address to capture |
| flush | output | 1 | One-cycle TLB flush request |
| walk_addr | output | PAW | Context table entry address |

## Verification
The embedded properties check the following on every cycle:
- The pointer and context registers never hold bits outside their masks.
- The implementation field always reads back as IMPL_VER.
- A flush pulse is always preceded by a write to the control or context index.
- Writes to unlisted indices leave every register untouched.
- A capture always wins the fault status.
- A read-clear empties that register.

Some behaviour can be shown only by the bench's scenarios, which compare against a reference model:
- A flush is absent when only unrelated control bits change or when a context write stores the same value.
- The table-walk sum is correct.
- The 0x13 read view does not clear.
- Both fault registers are loaded correctly in every read/write/capture collision that random stimulus produces.

// File: rtl/mmu_regbank.sv
module mmu_regbank #(
  parameter int          PAW      = 36,
  parameter logic [7:0]  IMPL_VER = 8'hF3,
  parameter int          EN_BIT   = 0,
  parameter int          NF_BIT   = 1,
  parameter int          BM_BIT   = 14,
  parameter logic [31:0] CTP_MASK = 32'h007F_FFF0,
  parameter logic [31:0] CTX_MASK = 32'h0000_003F,
  parameter logic [31:0] FSR_MASK = 32'h0001_6FFF,
  parameter logic [31:0] TRC_MASK = 32'h00FF_FFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [4:0]     idx,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic           fault_cap,
  input  logic [31:0]    fault_status_in,
  input  logic [31:0]    fault_addr_in,
  output logic           flush,
  output logic [PAW-1:0] walk_addr
);

  localparam logic [4:0] IX_CTRL = 5'h00;
  localparam logic [4:0] IX_CTP  = 5'h01;
  localparam logic [4:0] IX_CTX  = 5'h02;
  localparam logic [4:0] IX_FSRC = 5'h03;
  localparam logic [4:0] IX_FAR  = 5'h04;
  localparam logic [4:0] IX_TRC  = 5'h10;
  localparam logic [4:0] IX_FSR  = 5'h13;
  localparam logic [4:0] IX_FARW = 5'h14;
  localparam logic [31:0] MODE_BITS = (32'h1 << EN_BIT) | (32'h1 << NF_BIT) | (32'h1 << BM_BIT);

  logic [31:0] ctrl_q, ctp_q, ctx_q, fsr_q, far_q, trc_q;
  logic [31:0] ctrl_nx, ctx_nx;
  logic        wr_ctrl, wr_ctp, wr_ctx, wr_trc, wr_fsr, wr_far, rd_clr, listed;
  logic        flush_nx;

  assign wr_ctrl = wr_en && (idx == IX_CTRL);
  assign wr_ctp  = wr_en && (idx == IX_CTP);
  assign wr_ctx  = wr_en && (idx == IX_CTX);
  assign wr_trc  = wr_en && (idx == IX_TRC);
  assign wr_fsr  = wr_en && (idx == IX_FSR);
  assign wr_far  = wr_en && (idx == IX_FARW);
  assign rd_clr  = rd_en && (idx == IX_FSRC);
  assign listed  = (idx == IX_CTRL) || (idx == IX_CTP) || (idx == IX_CTX) || (idx == IX_FSRC) ||
                   (idx == IX_FAR) || (idx == IX_TRC) || (idx == IX_FSR) || (idx == IX_FARW);

  assign ctrl_nx  = {ctrl_q[31:24], wdata[23:0]};
  assign ctx_nx   = wdata & CTX_MASK;
  assign flush_nx = (wr_ctrl && (((ctrl_nx ^ ctrl_q) & MODE_BITS) != 32'h0)) ||
                    (wr_ctx && (ctx_nx != ctx_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= {IMPL_VER, 24'h0};
      ctp_q  <= '0;
      ctx_q  <= '0;
      trc_q  <= '0;
      fsr_q  <= '0;
      far_q  <= '0;
      flush  <= 1'b0;
    end else begin
      flush <= flush_nx;
      if (wr_ctrl) ctrl_q <= ctrl_nx;
      if (wr_ctp)  ctp_q  <= wdata & CTP_MASK;
      if (wr_ctx)  ctx_q  <= ctx_nx;
      if (wr_trc)  trc_q  <= wdata & TRC_MASK;
      if (fault_cap)   fsr_q <= fault_status_in & FSR_MASK;
      else if (wr_fsr) fsr_q <= wdata & FSR_MASK;
      else if (rd_clr) fsr_q <= '0;
      if (fault_cap)   far_q <= fault_addr_in;
      else if (wr_far) far_q <= wdata;
    end
  end

  always_comb begin
    case (idx)
      IX_CTRL:          rdata = ctrl_q;
      IX_CTP:           rdata = ctp_q;
      IX_CTX:           rdata = ctx_q;
      IX_FSRC, IX_FSR:  rdata = fsr_q;
      IX_FAR, IX_FARW:  rdata = far_q;
      IX_TRC:           rdata = trc_q;
      default:          rdata = '0;
    endcase
  end

  assign walk_addr = (PAW'(ctp_q) << 4) + (PAW'(ctx_q) << 2);

  a_r2_impl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IX_CTRL) |-> (rdata[31:24] == IMPL_VER));

  a_r4_ctp_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctp_q & ~CTP_MASK) == 32'h0);

  a_r5_ctx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q & ~CTX_MASK) == 32'h0);

  a_r3_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(wr_en && ((idx == IX_CTRL) || (idx == IX_CTX))));

  a_r10_unlisted_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !listed && !fault_cap) |=> ($stable(ctrl_q) && $stable(ctp_q) && $stable(ctx_q) &&
                                          $stable(trc_q) && $stable(fsr_q) && $stable(far_q) && !flush));

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !fault_cap) |=> (fsr_q == 32'h0));

  a_r12_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cap |=> ((fsr_q == $past(fault_status_in & FSR_MASK)) && (far_q == $past(fault_addr_in))));

endmodule

// File: tb/mmu_regbank_tb.sv
`timescale 1ns/1ps
module mmu_regbank_tb;
  localparam int          PAW      = 36;
  localparam logic [7:0]  IMPL     = 8'hF3;
  localparam logic [31:0] CTPM     = 32'h007F_FFF0;
  localparam logic [31:0] CTXM     = 32'h0000_003F;
  localparam logic [31:0] FSRM     = 32'h0001_6FFF;
  localparam logic [31:0] TRCM     = 32'h00FF_FFFF;
  localparam logic [31:0] MODEM    = 32'h0000_4003;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, fault_cap = 0;
  logic [4:0] idx = 0;
  logic [31:0] wdata = 0, fault_status_in = 0, fault_addr_in = 0;
  logic [31:0] rdata;
  logic flush;
  logic [PAW-1:0] walk_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_ctrl, m_ctp, m_ctx, m_fsr, m_far, m_trc;

  always #2.5 clk = ~clk;

  mmu_regbank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
    .wdata(wdata), .rdata(rdata), .fault_cap(fault_cap), .fault_status_in(fault_status_in),
    .fault_addr_in(fault_addr_in), .flush(flush), .walk_addr(walk_addr));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [4:0] i);
    case (i)
      5'h00: return m_ctrl;
      5'h01: return m_ctp;
      5'h02: return m_ctx;
      5'h03, 5'h13: return m_fsr;
      5'h04, 5'h14: return m_far;
      5'h10: return m_trc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [4:0] i);
    case (i)
      5'h00: return "R2";
      5'h01: return "R4";
      5'h02: return "R5";
      5'h03, 5'h04, 5'h13, 5'h14: return "R8";
      5'h10: return "R7";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [PAW-1:0] m_walk();
    return (PAW'(m_ctp) << 4) + (PAW'(m_ctx) << 2);
  endfunction

  task automatic op(bit w, bit r, bit c, logic [4:0] i, logic [31:0] d, logic [31:0] s, logic [31:0] a);
    bit ef;
    string ft;
    @(negedge clk);
    wr_en = w; rd_en = r; fault_cap = c; idx = i; wdata = d;
    fault_status_in = s; fault_addr_in = a;
    #1;
    if (r) chk((i == 5'h03) ? "R11" : rtag(i), rdata, m_read(i));
    ef = 0;
    if (w && i == 5'h00) ef = ((({IMPL, d[23:0]}) ^ m_ctrl) & MODEM) != 0;
    if (w && i == 5'h02) ef = (d & CTXM) != m_ctx;
    ft = (i == 5'h00) ? "R3" : (i == 5'h02) ? "R5" : (i == 5'h03 || i == 5'h04) ? "R6" : "R10";
    if (w) case (i)
      5'h00: m_ctrl = {IMPL, d[23:0]};
      5'h01: m_ctp = d & CTPM;
      5'h02: m_ctx = d & CTXM;
      5'h10: m_trc = d & TRCM;
      5'h13: m_fsr = d & FSRM;
      5'h14: m_far = d;
      default: ;
    endcase
    if (c) begin m_fsr = s & FSRM; m_far = a; end
    else if (r && i == 5'h03) m_fsr = 0;
    @(negedge clk);
    chk(ft, flush, ef);
    wr_en = 0; rd_en = 0; fault_cap = 0;
  endtask

  task automatic check_all();
    logic [4:0] lst [9] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h10, 5'h13, 5'h14, 5'h0B};
    @(negedge clk);
    chk("R3", flush, 0);
    chk("R9", walk_addr, m_walk());
    for (int k = 0; k < 9; k++) begin
      idx = lst[k];
      #0.2;
      chk(rtag(lst[k]), rdata, m_read(lst[k]));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ctrl = {IMPL, 24'h0}; m_ctp = 0; m_ctx = 0; m_fsr = 0; m_far = 0; m_trc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idx = 5'h00; #0.2; chk("R1", rdata, {IMPL, 24'h0});
    idx = 5'h01; #0.2; chk("R1", rdata, 0);
    idx = 5'h13; #0.2; chk("R1", rdata, 0);
    chk("R1", flush, 0);
    chk("R1", walk_addr, 0);

    op(1,0,0,5'h00,32'hFFFF_FFFF,0,0); check_all();
    op(1,0,0,5'h00,32'hFFFF_FFFF,0,0);
    op(1,0,0,5'h00,32'h00FF_FFDF,0,0);
    op(1,0,0,5'h00,32'h00FF_BFDF,0,0);
    op(1,0,0,5'h00,32'h00FF_BFDE,0,0);
    op(1,0,0,5'h00,32'h00FF_BFDC,0,0); check_all();
    op(1,0,0,5'h01,32'hFFFF_FFFF,0,0);
    op(1,0,0,5'h02,32'h0000_01FF,0,0);
    op(1,0,0,5'h02,32'h0000_00FF,0,0); check_all();
    chk("R9", walk_addr, 36'h0_07FF_FFFC);
    op(1,0,0,5'h10,32'hFFFF_FFFF,0,0);
    op(1,0,0,5'h13,32'hFFFF_FFFF,0,0);
    op(1,0,0,5'h14,32'hDEAD_BEEF,0,0); check_all();
    op(1,0,0,5'h03,32'h0,0,0);
    op(1,0,0,5'h04,32'h0,0,0); check_all();
    op(1,0,0,5'h05,32'h0,0,0);
    op(1,0,0,5'h1F,32'hFFFF_FFFF,0,0); check_all();
    op(0,1,0,5'h13,0,0,0); check_all();
    op(0,1,0,5'h03,0,0,0); check_all();
    chk("R11", m_fsr, 0);
    op(0,1,1,5'h03,0,32'hFFFF_FFFF,32'h1234_5678); check_all();
    op(1,0,1,5'h13,32'h0000_0001,32'h0000_0F00,32'hAAAA_5555); check_all();
    op(1,0,1,5'h14,32'h0000_0001,32'h0000_0002,32'h0BAD_F00D); check_all();

    for (int n = 0; n < 400; n++) begin
      logic [4:0] pick [9] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h10, 5'h13, 5'h14, 5'h00};
      logic [4:0] i;
      logic [31:0] d;
      i = pick[$urandom_range(0, 8)];
      if ($urandom_range(0, 9) == 0) i = 5'($urandom);
      d = $urandom;
      if ($urandom_range(0, 1) == 1) d = (i == 5'h02) ? (m_ctx | (d & 32'hFFFF_FF00)) : (m_ctrl ^ (d & 32'h00FF_0FF0));
      op(1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0), i, d, $urandom, $urandom);
      check_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule